// File: doc/BRIEF.md
# Input-to-Event Routing Matrix

This block steers a group of general-purpose input pins onto four internal event lines: the clock/gate inputs of two timers and two interrupt request lines, one high priority and one low priority. Each pin has its own 3-bit destination code. The code picks the consumer, and for the interrupt lines it also picks whether a rising or a falling transition of the pin raises the request. Several pins may select the same destination. Their contributions are then merged by a logical OR, so each consumer sees exactly one wire.

Every pin is brought into the clock domain through a two-flop synchronizer. Edges are found on the synchronized level. Timer outputs carry levels. Interrupt outputs carry one-clock pulses. The destination codes are captured into internal registers, so a new code acts from the next clock onward. Because edge detection works on pin history and not on routed signals, rewriting a code never produces a pulse of its own. The default build has eleven pins. Bit 0 is the push-button input, bit 1 the combined optical-receive/general pin, bit 2 the next general pin, and bits 3 to 10 the remaining eight general pins.

Top module: `evt_route_matrix`

## Requirements
- R1: While reset is asserted, and after it until a nonzero code is written, all four outputs are low and all captured codes are 000.
- R2: A pin level change reaches a timer output routed to it on the second rising clock edge after the change.
- R3: Code 010 routes the synchronized pin level to `tmr0_o`, and code 011 routes it to `tmr1_o`.
- R4: Code 100 raises a one-cycle pulse on `irq_hi_o` for a rising pin edge, and code 110 does so for a falling edge. Edges of the other polarity raise nothing.
- R5: Code 101 raises a one-cycle pulse on `irq_lo_o` for a rising edge, and code 111 does so for a falling edge.
- R6: Pins sharing a destination are combined by OR. Coincident edges give a single pulse, and a timer output is high while any routed pin is high.
- R7: Code 000 and reserved code 001 connect the pin to no output.
- R8: A code written before a clock edge governs the outputs from that edge onward. A code change while the pin is steady produces no interrupt pulse.
- R9: A timer output with no pin routed to it stays low.
- R10: Pin i is controlled only by bits [3i+2:3i] of `sel_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw asynchronous pin levels |
| sel_i | input | 3*NUM_PINS | Destination codes, 3 bits per pin |
| tmr0_o | output | 1 | Timer 0 clock/gate level |
| tmr1_o | output | 1 | Timer 1 clock/gate level |
| irq_hi_o | output | 1 | High-priority interrupt pulse |
| irq_lo_o | output | 1 | Low-priority interrupt pulse |

## Verification
Two situations can land in the same cycle. In the first, a synchronized edge reaches the decoder in the cycle that its pin's code is rewritten. In the second, edges from two pins on the same interrupt line coincide. The bench provokes both: it rewrites codes at random while pins toggle at random, and it adds directed cases with code flips on a steady pin and simultaneous edges on two pins. A bench model of the pin history and the captured codes predicts every output in every cycle. Under that model, a coincident pair must give exactly one pulse, and a code flip must judge the edge with the code captured at that edge.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    DST_NONE    = 3'b000,
    DST_RSVD    = 3'b001,
    DST_TMR0    = 3'b010,
    DST_TMR1    = 3'b011,
    DST_HI_RISE = 3'b100,
    DST_LO_RISE = 3'b101,
    DST_HI_FALL = 3'b110,
    DST_LO_FALL = 3'b111
  } dst_code_e;

  typedef struct packed {
    logic tmr0;
    logic tmr1;
    logic hi;
    logic lo;
  } evt_vec_t;

  // Contribution of one pin to the four consumers.
  function automatic evt_vec_t route_one(logic [CODE_W-1:0] code,
                                         logic lvl, logic rise, logic fall);
    evt_vec_t v;
    v = '0;
    unique case (dst_code_e'(code))
      DST_TMR0:    v.tmr0 = lvl;
      DST_TMR1:    v.tmr1 = lvl;
      DST_HI_RISE: v.hi   = rise;
      DST_HI_FALL: v.hi   = fall;
      DST_LO_RISE: v.lo   = rise;
      DST_LO_FALL: v.lo   = fall;
      default:     v      = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  localparam int LAST = STAGES - 1;

  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pin_i;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[LAST];
  end

  assign lvl_o  = stg[LAST];
  assign rise_o = stg[LAST] & ~prev_q;
  assign fall_o = ~stg[LAST] & prev_q;

endmodule

// File: rtl/pin_route_decode.sv
module pin_route_decode
  import evt_route_pkg::*;
#(
  parameter int N = 11
) (
  input  logic [N*CODE_W-1:0] sel_i,
  input  logic [N-1:0]        lvl_i,
  input  logic [N-1:0]        rise_i,
  input  logic [N-1:0]        fall_i,
  output logic [N-1:0]        tmr0_hit_o,
  output logic [N-1:0]        tmr1_hit_o,
  output logic [N-1:0]        hi_hit_o,
  output logic [N-1:0]        lo_hit_o
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    evt_vec_t v;
    always_comb v = route_one(sel_i[i*CODE_W +: CODE_W], lvl_i[i], rise_i[i], fall_i[i]);
    assign tmr0_hit_o[i] = v.tmr0;
    assign tmr1_hit_o[i] = v.tmr1;
    assign hi_hit_o[i]   = v.hi;
    assign lo_hit_o[i]   = v.lo;
  end

endmodule

// File: rtl/evt_route_matrix.sv
module evt_route_matrix
  import evt_route_pkg::*;
#(
  parameter int NUM_PINS    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PINS-1:0]        pin_i,
  input  logic [NUM_PINS*CODE_W-1:0] sel_i,
  output logic                       tmr0_o,
  output logic                       tmr1_o,
  output logic                       irq_hi_o,
  output logic                       irq_lo_o
);
  localparam int SEL_BITS = NUM_PINS * CODE_W;

  logic [SEL_BITS-1:0] sel_q;
  logic [NUM_PINS-1:0] lvl_w, rise_w, fall_w;
  logic [NUM_PINS-1:0] tmr0_hit_w, tmr1_hit_w, hi_hit_w, lo_hit_w;
  logic [NUM_PINS-1:0] tmr0_routed_w;
  logic                past_ok_q;

  // Captured destination codes: a write acts from the next edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok_q <= 1'b0;
    else        past_ok_q <= 1'b1;
  end

  pin_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  pin_route_decode #(.N(NUM_PINS)) u_dec (
    .sel_i      (sel_q),
    .lvl_i      (lvl_w),
    .rise_i     (rise_w),
    .fall_i     (fall_w),
    .tmr0_hit_o (tmr0_hit_w),
    .tmr1_hit_o (tmr1_hit_w),
    .hi_hit_o   (hi_hit_w),
    .lo_hit_o   (lo_hit_w)
  );

  // Merge: pins sharing a destination are ORed.
  assign tmr0_o   = |tmr0_hit_w;
  assign tmr1_o   = |tmr1_hit_w;
  assign irq_hi_o = |hi_hit_w;
  assign irq_lo_o = |lo_hit_w;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_rt
    assign tmr0_routed_w[i] = (sel_q[i*CODE_W +: CODE_W] == DST_TMR0);
  end

  AST_SEL_NEXT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok_q |-> sel_q == $past(sel_i)); // R8

  AST_NO_PULSE_STEADY_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && lvl_w == $past(lvl_w)) |-> !(irq_hi_o || irq_lo_o)); // R8

  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi_o || irq_lo_o) |-> |(rise_w | fall_w)); // R4

  AST_TMR0_UNROUTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr0_routed_w == '0) |-> !tmr0_o); // R9

  AST_TMR0_FOLLOWS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    tmr0_o |-> |(tmr0_routed_w & lvl_w)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(tmr0_o || tmr1_o || irq_hi_o || irq_lo_o)); // R1

endmodule

// File: tb/evt_route_matrix_tb.sv
module evt_route_matrix_tb;
  localparam int NP = 11;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [NP*CW-1:0] sel_i = '0;
  logic tmr0_o, tmr1_o, irq_hi_o, irq_lo_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evt_route_matrix #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sel_i(sel_i),
    .tmr0_o(tmr0_o), .tmr1_o(tmr1_o), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
  );

  // Bench model: pin history three clocks deep and captured codes.
  logic [NP-1:0] m1, m2, m3;
  logic [NP*CW-1:0] ms;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m1 <= '0; m2 <= '0; m3 <= '0; ms <= '0; end
    else begin m1 <= pin_i; m2 <= m1; m3 <= m2; ms <= sel_i; end
  end

  function automatic logic exp_out(int which, logic [NP*CW-1:0] s,
                                   logic [NP-1:0] now, logic [NP-1:0] old);
    logic r = 1'b0;
    for (int i = 0; i < NP; i++) begin
      logic [2:0] c = s[i*CW +: CW];
      logic up = now[i] & ~old[i];
      logic dn = ~now[i] & old[i];
      case (which)
        0: r |= (c == 3'd2) & now[i];
        1: r |= (c == 3'd3) & now[i];
        2: r |= ((c == 3'd4) & up) | ((c == 3'd6) & dn);
        default: r |= ((c == 3'd5) & up) | ((c == 3'd7) & dn);
      endcase
    end
    return r;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  // Continuous comparison with the model, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      check("R3 tmr0", tmr0_o, exp_out(0, ms, m2, m3));
      check("R3 tmr1", tmr1_o, exp_out(1, ms, m2, m3));
      check("R4 irq_hi", irq_hi_o, exp_out(2, ms, m2, m3));
      check("R5 irq_lo", irq_lo_o, exp_out(3, ms, m2, m3));
    end
  end

  task automatic tick(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #2;
    end
  endtask

  function automatic logic [NP*CW-1:0] one_code(int pin, logic [2:0] c);
    logic [NP*CW-1:0] s = '0;
    s[pin*CW +: CW] = c;
    return s;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    int pulses;
    process::self().srandom(32'd7);
    // R1: outputs quiet during reset even with pins moving.
    pin_i = '1; sel_i = '1;
    tick(3);
    check("R1 reset tmr0", tmr0_o, 1'b0);
    check("R1 reset irq_hi", irq_hi_o, 1'b0);
    pin_i = '0; sel_i = '0;
    tick(1);
    rst_n = 1'b1;
    for (int k = 0; k < 6; k++) begin
      pin_i = NP'($urandom);
      tick(1);
      check("R1 idle", tmr0_o | tmr1_o | irq_hi_o | irq_lo_o, 1'b0);
    end
    pin_i = '0; tick(4);

    // R2: latency of two edges through the synchronizer.
    sel_i = one_code(0, 3'b010); tick(2);
    pin_i[0] = 1'b1;
    tick(1); check("R2 after one edge", tmr0_o, 1'b0);
    tick(1); check("R2 after two edges", tmr0_o, 1'b1);
    pin_i[0] = 1'b0; tick(3);

    // R7: reserved and none codes drive nothing.
    sel_i = one_code(3, 3'b001) | one_code(4, 3'b000); tick(1);
    for (int k = 0; k < 8; k++) begin
      pin_i[3] = ~pin_i[3]; pin_i[4] = ~pin_i[4];
      tick(1);
      check("R7 unrouted", tmr0_o | tmr1_o | irq_hi_o | irq_lo_o, 1'b0);
    end
    pin_i = '0; tick(3);

    // R8: code flips on a steady high pin raise no pulse.
    pin_i[5] = 1'b1; tick(4);
    sel_i = one_code(5, 3'b100); tick(1);
    check("R8 flip to hi rise", irq_hi_o, 1'b0);
    sel_i = one_code(5, 3'b110); tick(1);
    check("R8 flip to hi fall", irq_hi_o, 1'b0);
    sel_i = one_code(5, 3'b101); tick(1);
    check("R8 flip to lo rise", irq_lo_o, 1'b0);
    // R4: falling edge with 110 gives exactly one pulse.
    sel_i = one_code(5, 3'b110); tick(1);
    pin_i[5] = 1'b0;
    pulses = 0;
    for (int k = 0; k < 5; k++) begin tick(1); pulses += int'(irq_hi_o); end
    check("R4 one pulse", pulses == 1, 1'b1);

    // R6: coincident rising edges on two low-priority pins merge.
    sel_i = one_code(6, 3'b101) | one_code(7, 3'b101); tick(2);
    pin_i[6] = 1'b1; pin_i[7] = 1'b1;
    pulses = 0;
    for (int k = 0; k < 5; k++) begin tick(1); pulses += int'(irq_lo_o); end
    check("R6 merged pulse", pulses == 1, 1'b1);
    // R6: timer stays high while either routed pin is high.
    sel_i = one_code(6, 3'b011) | one_code(7, 3'b011); tick(1);
    pin_i[6] = 1'b0; tick(3);
    check("R6 timer OR", tmr1_o, 1'b1);
    pin_i = '0; tick(3);

    // R9: nothing routed to timer0 while pins toggle.
    sel_i = one_code(1, 3'b011);
    for (int k = 0; k < 6; k++) begin
      pin_i = ~pin_i; tick(1);
      check("R9 tmr0 low", tmr0_o, 1'b0);
    end
    pin_i = '0; tick(3);

    // R10: each pin's own field routes it to timer1.
    for (int i = 0; i < NP; i++) begin
      sel_i = one_code(i, 3'b011);
      pin_i = ~(NP'(1) << i);
      tick(3);
      check("R10 other pins", tmr1_o, 1'b0);
      pin_i = NP'(1) << i;
      tick(3);
      check("R10 own pin", tmr1_o, 1'b1);
    end
    pin_i = '0; sel_i = '0; tick(3);

    // Random mix: pins and codes change, the model judges every cycle.
    for (int k = 0; k < 3000; k++) begin
      if (($urandom % 4) == 0) pin_i = NP'($urandom);
      else pin_i[$urandom % NP] = ~pin_i[$urandom % NP];
      if (($urandom % 5) == 0) sel_i[($urandom % NP)*CW +: CW] = 3'($urandom);
      tick(1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule